// File: doc/BRIEF.md
# DAQ Interrupt, DMA and Pacer Gating Control

This block is the host-facing control slice of a data acquisition front end. Software writes a control register that turns on interrupts and DMA, picks one of eight interrupt level codes, and chooses the conversion-start source. A second register, which software can only write, decides two things. It decides whether an on-board reference clock is ANDed into the counter 0 clock. It also decides whether the external trigger pin gates the pacer.

An external trigger pin is synchronized into the clock domain. Its rising edge sets an interrupt flag. That flag is steered onto exactly one host interrupt line, and only while interrupts are enabled. Software clears the flag by writing any value to the status address. DMA requests from the converter side reach the host only while DMA is enabled.

The counters, the converter and the channel multiplexer are outside this block. It produces only the gated counter clock, the pacer gate, the interrupt lines, the qualified DMA request and the trigger-source code.

Top module: `daq_irq_dma_pacer`

## Requirements
- R1: After reset, the following hold. The control register reads 0. The trigger-source output is 0, which means software start only. All interrupt lines are low and no DMA request passes. The pacer gate is high. The counter 0 clock follows the external counter pin alone.
- R2: The control register is at address 1 and can be read and written. Bits 1:0 are the trigger-source code and drive `trig_src_o` directly. Bit 2 enables DMA. Bit 3 is not stored and reads 0. Bits 6:4 are the interrupt level code. Bit 7 enables interrupts.
- R3: With interrupts enabled and the flag set, `irq_lines_o[n]` drives host line n. Level codes 2 to 7 drive lines 2 to 7. Code 0 drives line 10 and code 1 drives line 11. At most one line is high.
- R4: While bit 7 of the control register is 0, all interrupt lines stay low, whatever the flag holds.
- R5: The trigger pin passes through a two-flop synchronizer. A rising edge of the pin sets the flag, which reads as bit 7 at address 0. The flag is visible after the third rising clock edge that follows the pin change, and not after the second. A pin that stays high never sets the flag.
- R6: Any write to address 0 clears the flag, whatever the data. If a synchronized rising edge arrives in the same cycle, the set wins.
- R7: `dma_req_o` is high only when `dma_req_i` is high and control bit 2 is 1.
- R8: The pacer register is at address 2 and can only be written. Bit 0 is the trigger gate enable and bit 1 is the reference clock enable. Bits 7:2 are ignored, and the address reads 0.
- R9: When pacer bit 1 is 1, the counter 0 clock is `ref_clk_i` AND `cnt0_pin_i`. When the bit is 0, the counter 0 clock equals `cnt0_pin_i`.
- R10: When pacer bit 0 is 1, the pacer gate equals the raw trigger pin. When the bit is 0, the gate is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 control, 2 pacer |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| trig_pin_i | input | 1 | External trigger pin (pulled up, asynchronous) |
| cnt0_pin_i | input | 1 | External counter 0 clock pin |
| ref_clk_i | input | 1 | On-board reference clock |
| dma_req_i | input | 1 | DMA request from the conversion side |
| dma_req_o | output | 1 | Qualified DMA request to the host |
| irq_lines_o | output | 16 | Host interrupt lines, bit n drives line n |
| trig_src_o | output | 2 | Conversion-start source code |
| cnt0_clk_o | output | 1 | Gated counter 0 clock |
| pacer_gate_o | output | 1 | Gate for pacer counters 1 and 2 |

## Verification
The hardest case is a status write that lands in the same cycle as a synchronized trigger edge. Reaching it requires counting the two synchronizer stages precisely. The bench raises the pin on a falling clock edge and lets two rising edges pass. It then issues the clear write so that it meets the detected edge at the third rising edge, and it expects the flag to survive. The level remap is walked through a vector table while the flag is held set, so that every code appears on the interrupt lines.

// File: rtl/daq_ctl_pkg.sv
`timescale 1ns/1ps
package daq_ctl_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned LVL_W      = 3;
  localparam int unsigned SRC_W      = 2;
  localparam int unsigned REMAP_BASE = 10;  // line for code 0
  localparam int unsigned REMAP_CNT  = 2;   // codes below this are remapped

  typedef struct packed {
    logic             inte;
    logic [LVL_W-1:0] lvl;
    logic             rsvd;
    logic             dma_en;
    logic [SRC_W-1:0] trig_src;
  } ctrl_reg_t;

  localparam logic [DATA_W-1:0] CTRL_MASK = 8'hF7;

  typedef enum logic [1:0] {
    ADR_STAT  = 2'd0,
    ADR_CTRL  = 2'd1,
    ADR_PACER = 2'd2
  } reg_adr_e;

  function automatic int unsigned line_of(input logic [LVL_W-1:0] lvl);
    if (int'(lvl) < int'(REMAP_CNT)) return REMAP_BASE + int'(lvl);
    return int'(lvl);
  endfunction
endpackage

// File: rtl/daq_ctl_regs.sv
`timescale 1ns/1ps
module daq_ctl_regs
  import daq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_reg_t         ctrl_o,
  output logic              trig0_o,
  output logic              ctr0_o,
  output logic              stat_wr_o
);
  ctrl_reg_t ctrl_q;
  logic      trig0_q, ctr0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      trig0_q <= 1'b0;
      ctr0_q  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(ADR_CTRL)) ctrl_q <= ctrl_reg_t'(wdata_i & CTRL_MASK);
      if (addr_i == ADDR_W'(ADR_PACER)) begin
        trig0_q <= wdata_i[0];
        ctr0_q  <= wdata_i[1];
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign trig0_o   = trig0_q;
  assign ctr0_o    = ctr0_q;
  assign stat_wr_o = wr_i && (addr_i == ADDR_W'(ADR_STAT));
endmodule

// File: rtl/daq_trig_flag.sv
`timescale 1ns/1ps
module daq_trig_flag #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic clr_i,
  output logic rise_o,
  output logic flag_o
);
  localparam int unsigned HIST = SYNC_STAGES + 1;

  // pin is pulled up: preload ones so reset release is not an edge
  logic [HIST-1:0] sh_q;
  logic            flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[HIST-2:0], pin_i};
  end

  assign rise_o = sh_q[HIST-2] & ~sh_q[HIST-1];

  // set has priority over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (rise_o) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/daq_irq_route.sv
`timescale 1ns/1ps
module daq_irq_route
  import daq_ctl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 en_i,
  input  logic [LVL_W-1:0]     lvl_i,
  output logic [NUM_LINES-1:0] lines_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lines_o[g] = en_i && (line_of(lvl_i) == g);
  end
endmodule

// File: rtl/daq_irq_dma_pacer.sv
`timescale 1ns/1ps
module daq_irq_dma_pacer
  import daq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic                 trig_pin_i,
  input  logic                 cnt0_pin_i,
  input  logic                 ref_clk_i,
  input  logic                 dma_req_i,
  output logic                 dma_req_o,
  output logic [NUM_LINES-1:0] irq_lines_o,
  output logic [1:0]           trig_src_o,
  output logic                 cnt0_clk_o,
  output logic                 pacer_gate_o
);
  ctrl_reg_t ctrl;
  logic      trig0, ctr0, stat_wr, trig_rise, int_flag;

  daq_ctl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl), .trig0_o(trig0), .ctr0_o(ctr0), .stat_wr_o(stat_wr)
  );

  daq_trig_flag #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
    .clk_i, .rst_ni, .pin_i(trig_pin_i), .clr_i(stat_wr),
    .rise_o(trig_rise), .flag_o(int_flag)
  );

  daq_irq_route #(.NUM_LINES(NUM_LINES)) u_route (
    .en_i(ctrl.inte & int_flag), .lvl_i(ctrl.lvl), .lines_o(irq_lines_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_W'(ADR_STAT): rdata_o = {int_flag, 7'b0};
      ADDR_W'(ADR_CTRL): rdata_o = ctrl;
      default:           rdata_o = '0;
    endcase
  end

  assign dma_req_o    = dma_req_i & ctrl.dma_en;
  assign trig_src_o   = ctrl.trig_src;
  assign cnt0_clk_o   = ctr0 ? (ref_clk_i & cnt0_pin_i) : cnt0_pin_i;
  assign pacer_gate_o = trig0 ? trig_pin_i : 1'b1;
endmodule

// File: rtl/daq_irq_dma_pacer_chk.sv
`timescale 1ns/1ps
module daq_irq_dma_pacer_chk #(
  parameter int unsigned NUM_LINES = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 inte,
  input logic                 dma_en,
  input logic                 trig0,
  input logic                 stat_wr,
  input logic                 trig_rise,
  input logic                 int_flag,
  input logic                 dma_req_i,
  input logic                 dma_req_o,
  input logic                 pacer_gate_o,
  input logic [NUM_LINES-1:0] irq_lines_o
);
  a_r3_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_lines_o));
  a_r4_inte_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inte |-> (irq_lines_o == '0));
  a_r5_set_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_flag) |-> $past(trig_rise));
  a_r6_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !trig_rise) |=> !int_flag);
  a_r7_dma_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (dma_en && dma_req_i));
  a_r10_gate_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig0 |-> pacer_gate_o);
endmodule

bind daq_irq_dma_pacer daq_irq_dma_pacer_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i, .rst_ni,
  .inte(ctrl.inte), .dma_en(ctrl.dma_en), .trig0(trig0),
  .stat_wr(stat_wr), .trig_rise(trig_rise), .int_flag(int_flag),
  .dma_req_i, .dma_req_o, .pacer_gate_o, .irq_lines_o
);

// File: tb/daq_irq_dma_pacer_test.sv
`timescale 1ns/1ps
module daq_irq_dma_pacer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        trig = 1'b1, cpin = 1'b1, rclk = 1'b1, dreq = 1'b1;
  logic        dreq_o, cclk, gate;
  logic [15:0] lines;
  logic [1:0]  tsrc;
  int          errs = 0, checks = 0;

  always #4 clk = ~clk;

  daq_irq_dma_pacer uut (
    .clk_i(clk), .rst_ni, .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .trig_pin_i(trig), .cnt0_pin_i(cpin), .ref_clk_i(rclk), .dma_req_i(dreq),
    .dma_req_o(dreq_o), .irq_lines_o(lines), .trig_src_o(tsrc),
    .cnt0_clk_o(cclk), .pacer_gate_o(gate)
  );

  // {ctrl write, expected lines}
  localparam logic [23:0] TBL [10] = '{
    {8'h80, 16'h0400}, {8'h91, 16'h0800}, {8'hA2, 16'h0004}, {8'hB3, 16'h0008},
    {8'hC0, 16'h0010}, {8'hD5, 16'h0020}, {8'hEA, 16'h0040}, {8'hFF, 16'h0080},
    {8'hAF, 16'h0004}, {8'h7F, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic raise_trig();
    trig = 1'b0;
    repeat (4) @(negedge clk);
    trig = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    rd_reg(2'd1, rv);       chk("R1 ctrl reset", rv, 8'h00);
    chk("R1 irq reset", lines, 16'h0);
    chk("R1 dma blocked", dreq_o, 1'b0);
    chk("R1 gate high", gate, 1'b1);
    chk("R1 trig src", tsrc, 2'd0);
    rd_reg(2'd0, rv);       chk("R5 steady high no flag", rv, 8'h00);
    rclk = 1'b0; cpin = 1'b1; #1; chk("R1 cnt0 follows pin hi", cclk, 1'b1);
    cpin = 1'b0; #1;              chk("R1 cnt0 follows pin lo", cclk, 1'b0);
    cpin = 1'b1;

    // R5 synchronizer latency
    trig = 1'b0;
    repeat (4) @(negedge clk);
    trig = 1'b1;
    repeat (2) @(negedge clk);
    rd_reg(2'd0, rv);       chk("R5 not after 2 edges", rv, 8'h00);
    @(negedge clk);
    rd_reg(2'd0, rv);       chk("R5 set after 3 edges", rv, 8'h80);

    for (int i = 0; i < 10; i++) begin
      wr_reg(2'd1, TBL[i][23:16]);
      rd_reg(2'd1, rv);
      chk("R2 readback", rv, TBL[i][23:16] & 8'hF7);
      chk("R2 trig src out", tsrc, TBL[i][17:16]);
      chk(TBL[i][23] ? "R3 level route" : "R4 inte off", lines, TBL[i][15:0]);
    end

    // R6 clears with any data
    wr_reg(2'd1, 8'hD0);    chk("R3 line5", lines, 16'h0020);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, rv);       chk("R6 clear data 00", rv, 8'h00);
    chk("R6 lines drop", lines, 16'h0);
    raise_trig();
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, rv);       chk("R6 clear data FF", rv, 8'h00);

    // R6 set wins over simultaneous clear
    trig = 1'b0;
    repeat (4) @(negedge clk);
    trig = 1'b1;
    repeat (2) @(negedge clk);
    wr_reg(2'd0, 8'h5A);
    rd_reg(2'd0, rv);       chk("R6 set wins", rv, 8'h80);

    // R7
    wr_reg(2'd1, 8'h04);
    dreq = 1'b1; #1;        chk("R7 dma pass", dreq_o, 1'b1);
    dreq = 1'b0; #1;        chk("R7 dma idle", dreq_o, 1'b0);
    wr_reg(2'd1, 8'h00);
    dreq = 1'b1; #1;        chk("R7 dma blocked", dreq_o, 1'b0);

    // R8 upper bits ignored, write-only
    wr_reg(2'd1, 8'h95);
    wr_reg(2'd2, 8'hFC);
    rd_reg(2'd2, rv);       chk("R8 reads zero", rv, 8'h00);
    rd_reg(2'd1, rv);       chk("R8 ctrl untouched", rv, 8'h95);
    trig = 1'b0; #1;        chk("R8 trig gate off", gate, 1'b1);
    rclk = 1'b0; cpin = 1'b1; #1; chk("R8 ref gate off", cclk, 1'b1);

    // R10
    wr_reg(2'd2, 8'h01);
    trig = 1'b0; #1;        chk("R10 gate low", gate, 1'b0);
    trig = 1'b1; #1;        chk("R10 gate high", gate, 1'b1);

    // R9
    wr_reg(2'd2, 8'h02);
    chk("R10 gate held", gate, 1'b1);
    rclk = 1'b0; cpin = 1'b1; #1; chk("R9 ref low", cclk, 1'b0);
    rclk = 1'b1; cpin = 1'b1; #1; chk("R9 both high", cclk, 1'b1);
    rclk = 1'b1; cpin = 1'b0; #1; chk("R9 pin low", cclk, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule